// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a three-wire serial slave that holds sixteen 8-bit configuration registers. A host pulls the enable line low, clocks a command in on the data input with rising shift-clock edges, then raises the enable. The rising edge of the enable commits the command. A write command stores its data byte in the addressed register. A read command does not return data at once. It only remembers the address. The register is shifted out on the serial output during the next enable-low period, on falling shift-clock edges.

The shift clock, enable and data input are asynchronous to the master clock. All three pass through the same synchronizer depth, and their edges are detected in the master-clock domain. The enable must stay high for at least a set number of master clocks between low periods. A shorter high period is flagged, and the command shifted in during the low period that follows is dropped. The register contents are brought out in parallel for the logic that uses them.

Top module: `cfg_serial_bank`

## Requirements
- R1: After reset, every register reads zero, the serial output is 0 and the gap-error flag is 0.
- R2: A committed 13-bit command with bit 12 = 0 writes bits 7:0 to the register selected by bits 11:8. Bits are sent MSB first, so bit 12 is the first bit shifted. No other register changes.
- R3: When more than 13 bits are shifted in one low period, only the last 13 bits before the enable rises are decoded.
- R4: A low period with fewer than 13 captured bits changes no register and arms no read.
- R5: A committed command with bit 12 = 1 leaves every register unchanged and arms a read of the register selected by bits 11:8. In the next low period, falling shift-clock edges 1 to 8 put that register on the serial output, MSB first.
- R6: The serial output is 0 from the ninth falling edge onwards, and it is 0 throughout any low period with no armed read. An armed read is served in one low period only.
- R7: If the enable is high for fewer than 3 master clocks between low periods, the gap-error flag pulses for one clock and the command of the following low period is discarded. A high time of exactly 3 clocks is accepted.
- R8: Shift-clock edges while the enable is high capture nothing and shift nothing out. An armed read keeps all 8 bits for the next low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sen_n_i | input | 1 | Frame enable, active low, asynchronous |
| sdi_i | input | 1 | Serial data in, captured on rising shift-clock edges |
| sdo_o | output | 1 | Serial data out, changes after falling shift-clock edges |
| gap_err_o | output | 1 | One-clock pulse when an enable-high period was too short |
| cfg_regs_o | output | 128 | All registers, register n at bits 8n+7:8n |

## Verification
The bench writes every register with a different value. It then reads all sixteen back in a chain, where each frame returns the previous address while it arms the next. A design that answered in the current frame, reversed the bit order or kept driving data past bit 8 would break this chain at once. Frames longer than 13 bits and frames one bit short check the decoding window. A decoder anchored at the first bit would store junk, and a missing length check would write a partial word. The enable high time is tried at 1, 2 and 3 clocks to pin the violation threshold, which catches an off-by-one in the high-time counter. Shift-clock toggles while the enable is high check that an armed read is not consumed early.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int unsigned DEF_ADDR_W   = 4;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_MIN_HIGH = 3;
  localparam int unsigned DEF_SYNC     = 2;

  // Command layout, MSB first: direction bit, address, data.
  function automatic int unsigned cmd_bits(input int unsigned aw, input int unsigned dw);
    return 1 + aw + dw;
  endfunction
endpackage

// File: rtl/cfg_sync_vec.sv
module cfg_sync_vec #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int unsigned FW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          bit_ev_i,
  input  logic          bit_i,
  output logic [FW-1:0] frame_o,
  output logic          full_o
);
  localparam int unsigned CW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == CW'(FW)) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (bit_ev_i) sh_q <= {sh_q[FW-2:0], bit_i};
      if (clear_i)       cnt_q <= bit_ev_i ? CW'(1) : '0;
      else if (bit_ev_i) cnt_q <= sat_inc(cnt_q);
    end
  end

  assign frame_o = sh_q;
  assign full_o  = (cnt_q == CW'(FW));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [DW-1:0]        rd_data_o,
  output logic [(DW<<AW)-1:0]  regs_o
);
  localparam int unsigned N = 1 << AW;

  logic [DW-1:0] word_q [N];

  for (genvar r = 0; r < N; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[r] <= '0;
      else if (wr_en_i && (wr_addr_i == AW'(r))) word_q[r] <= wr_data_i;
    end
    assign regs_o[r*DW +: DW] = word_q[r];
  end

  assign rd_data_o = word_q[rd_addr_i];
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_ev_i,
  input  logic          stop_i,
  output logic          sdo_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; active_q <= 1'b0; sdo_q <= 1'b0;
    end else if (stop_i) begin
      active_q <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (load_i) begin
      sh_q     <= data_i;
      cnt_q    <= '0;
      active_q <= 1'b1;
      sdo_q    <= 1'b0;
    end else if (shift_ev_i && active_q) begin
      if (cnt_q < CW'(DW)) begin
        sdo_q <= sh_q[DW-1];
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        sdo_q <= 1'b0;
      end
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfg_ser_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned MIN_HIGH = DEF_MIN_HIGH,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk_i,
  input  logic                            sen_n_i,
  input  logic                            sdi_i,
  output logic                            sdo_o,
  output logic                            gap_err_o,
  output logic [(DATA_W<<ADDR_W)-1:0]     cfg_regs_o
);
  localparam int unsigned FW  = cmd_bits(ADDR_W, DATA_W);
  localparam int unsigned HCW = $clog2(MIN_HIGH + 1);

  // synchronized lines, bit order {sdi, sen, sclk}
  logic [2:0] sync_s;
  cfg_sync_vec #(.W(3), .STAGES(SYNC), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sdi_i, sen_n_i, sclk_i}), .q_o(sync_s)
  );
  logic sclk_s, sen_s, sdi_s;
  assign sclk_s = sync_s[0];
  assign sen_s  = sync_s[1];
  assign sdi_s  = sync_s[2];

  logic sclk_q, sen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sen_q  <= sen_s;
    end
  end

  // named events
  logic sclk_rise_ev, sclk_fall_ev, sen_rise_ev, sen_fall_ev;
  logic bit_ev, shift_ev, commit_ev;
  assign sclk_rise_ev = sclk_s & ~sclk_q;
  assign sclk_fall_ev = ~sclk_s & sclk_q;
  assign sen_rise_ev  = sen_s & ~sen_q;
  assign sen_fall_ev  = ~sen_s & sen_q;
  assign bit_ev       = sclk_rise_ev & ~sen_s;
  assign shift_ev     = sclk_fall_ev & ~sen_s;
  assign commit_ev    = sen_rise_ev;

  // enable-high time check
  logic [HCW-1:0] hi_cnt_q;
  logic           gap_bad_ev, skip_q, gap_err_q;
  assign gap_bad_ev = sen_fall_ev & (hi_cnt_q < HCW'(MIN_HIGH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q  <= HCW'(MIN_HIGH);
      skip_q    <= 1'b0;
      gap_err_q <= 1'b0;
    end else begin
      if (!sen_s) hi_cnt_q <= '0;
      else if (hi_cnt_q < HCW'(MIN_HIGH)) hi_cnt_q <= hi_cnt_q + 1'b1;
      if (sen_fall_ev) skip_q <= gap_bad_ev;
      gap_err_q <= gap_bad_ev;
    end
  end
  assign gap_err_o = gap_err_q;

  // frame capture
  logic [FW-1:0] frame;
  logic          frame_full;
  cfg_frame_rx #(.FW(FW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear_i(sen_fall_ev), .bit_ev_i(bit_ev),
    .bit_i(sdi_s), .frame_o(frame), .full_o(frame_full)
  );

  logic              cmd_is_read;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  assign cmd_is_read = frame[FW-1];
  assign cmd_addr    = frame[DATA_W +: ADDR_W];
  assign cmd_data    = frame[DATA_W-1:0];

  logic frame_ok, wr_ev, rd_arm_ev, rd_start_ev;
  assign frame_ok  = frame_full & ~skip_q;
  assign wr_ev     = commit_ev & frame_ok & ~cmd_is_read;
  assign rd_arm_ev = commit_ev & frame_ok & cmd_is_read;

  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else if (rd_arm_ev) begin
      rd_pend_q <= 1'b1;
      rd_addr_q <= cmd_addr;
    end else if (sen_fall_ev) begin
      rd_pend_q <= 1'b0;
    end
  end
  assign rd_start_ev = sen_fall_ev & rd_pend_q;

  logic [DATA_W-1:0] rd_word;
  cfg_reg_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_ev), .wr_addr_i(cmd_addr),
    .wr_data_i(cmd_data), .rd_addr_i(rd_addr_q), .rd_data_o(rd_word),
    .regs_o(cfg_regs_o)
  );

  cfg_readback #(.DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(rd_start_ev), .data_i(rd_word),
    .shift_ev_i(shift_ev), .stop_i(sen_rise_ev), .sdo_o(sdo_o)
  );
endmodule

// File: rtl/cfg_serial_bank_chk.sv
module cfg_serial_bank_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sdo_o,
  input logic                        gap_err_o,
  input logic [(DATA_W<<ADDR_W)-1:0] cfg_regs_o,
  input logic                        wr_ev,
  input logic                        rd_arm_ev,
  input logic                        commit_ev,
  input logic                        frame_full,
  input logic                        skip_q,
  input logic                        sclk_fall_ev,
  input logic                        sen_rise_ev,
  input logic                        sen_fall_ev,
  input logic [ADDR_W-1:0]           cmd_addr,
  input logic [DATA_W-1:0]           cmd_data
);
  logic [ADDR_W-1:0] last_a;
  logic [DATA_W-1:0] last_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_a <= '0;
      last_d <= '0;
    end else begin
      last_a <= cmd_addr;
      last_d <= cmd_data;
    end
  end

  function automatic logic [DATA_W-1:0] word_at(input logic [(DATA_W<<ADDR_W)-1:0] v,
                                                 input logic [ADDR_W-1:0] a);
    return DATA_W'(v >> (a * DATA_W));
  endfunction

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> word_at(cfg_regs_o, last_a) == last_d);

  p_hold_unless_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(cfg_regs_o));

  p_short_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && !frame_full) |-> (!wr_ev && !rd_arm_ev));

  p_skip_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && skip_q) |-> (!wr_ev && !rd_arm_ev));

  p_gap_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err_o |-> $past(sen_fall_ev));

  p_sdo_edge_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sclk_fall_ev || sen_rise_ev));

  p_sdo_quiet_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise_ev |=> !sdo_o);
endmodule

bind cfg_serial_bank cfg_serial_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_o(sdo_o), .gap_err_o(gap_err_o),
  .cfg_regs_o(cfg_regs_o), .wr_ev(wr_ev), .rd_arm_ev(rd_arm_ev),
  .commit_ev(commit_ev), .frame_full(frame_full), .skip_q(skip_q),
  .sclk_fall_ev(sclk_fall_ev), .sen_rise_ev(sen_rise_ev),
  .sen_fall_ev(sen_fall_ev), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/test_cfg_serial_bank.sv
`timescale 1ns/1ps
module test_cfg_serial_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sen_n = 1'b1, sdi = 1'b0;
  logic sdo, gap_err;
  logic [127:0] regs;

  always #2 clk = ~clk;

  cfg_serial_bank i_cfg_serial_bank (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sen_n_i(sen_n), .sdi_i(sdi),
    .sdo_o(sdo), .gap_err_o(gap_err), .cfg_regs_o(regs)
  );

  int total = 0, bad = 0, gaps = 0;
  logic [7:0] model [16];
  bit done = 0;

  always @(posedge clk) if (rst_n && gap_err) gaps++;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [12:0] cmd(input bit rd, input int a, input int d);
    return {rd, 4'(a), 8'(d)};
  endfunction

  function automatic int pat(input int a);
    return ((a * 29 + 7) ^ (a << 4)) & 255;
  endfunction

  task automatic check_all(input string tag);
    int mism = 0;
    for (int a = 0; a < 16; a++) if (regs[a*8 +: 8] !== model[a]) mism++;
    check(tag, mism, 0);
  endtask

  // Shift nb bits (MSB first), then hold enable high for hi clocks.
  task automatic xfer(input int nb, input logic [31:0] bits, input int hi,
                      output logic [7:0] got, output int tail);
    got = '0; tail = 0;
    sen_n = 1'b0; wclk(4);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = bits[i]; wclk(3);
      sclk = 1'b1; wclk(4);
      sclk = 1'b0; wclk(4);
      if (nb - 1 - i < 8) got[7 - (nb - 1 - i)] = sdo;
      else tail += int'(sdo);
    end
    sdi = 1'b0; wclk(2);
    sen_n = 1'b1; wclk(hi);
  endtask

  initial begin
    logic [7:0] g;
    int tl, g0;
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    wclk(3);
    check("R1 regs zero", int'(regs != 0), 0);
    check("R1 sdo zero", int'(sdo), 0);
    check("R1 gap flag zero", int'(gap_err), 0);
    rst_n = 1'b1; wclk(4);

    // R2: write every register
    for (int a = 0; a < 16; a++) begin
      xfer(13, 32'(cmd(0, a, pat(a))), 8, g, tl);
      model[a] = 8'(pat(a));
      check("R2 written word", int'(regs[a*8 +: 8]), pat(a));
      check_all("R2 other words unchanged");
    end

    // R5/R6: chained read sweep
    xfer(13, 32'(cmd(1, 0, 8'hFF)), 8, g, tl);
    check("R6 no pending read gives 0", int'(g), 0);
    check_all("R5 read leaves regs");
    for (int a = 1; a <= 16; a++) begin
      xfer(13, 32'(cmd(a < 16, a % 16, 8'h5A)), 8, g, tl);
      check("R5 readback data", int'(g), pat(a - 1));
      check("R6 zero after eight bits", tl, 0);
    end
    model[0] = 8'h5A;
    check_all("R5 sweep end state");
    xfer(13, 32'(cmd(0, 0, pat(0))), 8, g, tl);
    model[0] = 8'(pat(0));
    check("R6 read served once", int'(g), 0);

    // R3: long frame, only last 13 bits count
    xfer(18, {14'h0, 5'b11111, cmd(0, 5, 8'h3C)}, 8, g, tl);
    model[5] = 8'h3C;
    check("R3 long frame word", int'(regs[5*8 +: 8]), 8'h3C);
    check_all("R3 long frame others");
    xfer(20, {12'h0, 7'b1010101, cmd(1, 5, 8'h00)}, 8, g, tl);
    xfer(13, 32'(cmd(0, 1, pat(1))), 8, g, tl);
    check("R3 long read armed", int'(g), 8'h3C);

    // R4: short frame dropped
    xfer(12, 32'(cmd(0, 6, 8'h99)), 8, g, tl);
    check_all("R4 short write ignored");
    xfer(12, 32'(cmd(1, 6, 8'h00)), 8, g, tl);
    xfer(13, 32'(cmd(0, 2, pat(2))), 8, g, tl);
    check("R4 short read not armed", int'(g), 0);

    // R8: shift-clock activity while enable high
    xfer(13, 32'(cmd(1, 9, 8'h00)), 8, g, tl);
    for (int k = 0; k < 5; k++) begin
      sdi = 1'b1; wclk(3); sclk = 1'b1; wclk(4); sclk = 1'b0; wclk(4);
      check("R8 sdo quiet while high", int'(sdo), 0);
    end
    sdi = 1'b0;
    check_all("R8 toggles change nothing");
    xfer(13, 32'(cmd(0, 3, pat(3))), 8, g, tl);
    check("R8 read kept all bits", int'(g), pat(9));

    // R7: enable high-time limit
    g0 = gaps;
    xfer(13, 32'(cmd(0, 4, pat(4))), 1, g, tl);
    xfer(13, 32'(cmd(0, 3, 8'hAA)), 8, g, tl);
    check("R7 gap flag at 1 clk", gaps - g0, 1);
    check("R7 frame after short gap dropped", int'(regs[3*8 +: 8]), pat(3));
    g0 = gaps;
    xfer(13, 32'(cmd(0, 4, pat(4))), 2, g, tl);
    xfer(13, 32'(cmd(0, 3, 8'hAB)), 8, g, tl);
    check("R7 gap flag at 2 clk", gaps - g0, 1);
    check("R7 dropped at 2 clk", int'(regs[3*8 +: 8]), pat(3));
    g0 = gaps;
    xfer(13, 32'(cmd(0, 4, pat(4))), 3, g, tl);
    xfer(13, 32'(cmd(0, 3, 8'hAC)), 8, g, tl);
    model[3] = 8'hAC;
    check("R7 no flag at 3 clk", gaps - g0, 0);
    check("R7 accepted at 3 clk", int'(regs[3*8 +: 8]), 8'hAC);
    check_all("R7 final state");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule